// File: doc/BRIEF.md
# Lock Wait Parking Table

This block keeps one slot for each hardware thread context of a multithreaded core. A context whose lock acquire fails is parked in its slot. The slot holds the lock address and the program counter of the acquiring instruction. The context is then held blocked, and a one-cycle flush request asks the pipeline to drop that context's in-flight work. The pipeline logic that acts on the flush request is outside this block.

Every lock release is checked against all occupied slots in the same cycle. When a parked context waits on the released address, that context gets a one-cycle wake pulse on the next cycle. In the same cycle, the block drives the program counter the context must restart from. The slot is freed on the same edge. Only one context is woken per release, so the other waiters stay parked until later releases.

Top module: `lock_park_table`

## Requirements
- R1: After reset, all slots are empty and `block_o`, `wake_o`, `flush_o` and `restart_pc_o` are all zero.
- R2: A fail request stores `fail_lock_i` and `fail_pc_i` in slot `fail_ctx_i`. From the next cycle, `block_o[fail_ctx_i]` is high, and `flush_o[fail_ctx_i]` is high for exactly that one cycle. A fail on an occupied slot overwrites it.
- R3: A release compares `rel_lock_i` with every occupied slot in the same cycle. When some slot matches, the matching context's bit in `wake_o` is high for exactly one cycle, starting the cycle after the release.
- R4: In a cycle where `wake_o` has a bit set, `restart_pc_o` equals the program counter stored for the woken context. In every other cycle, `restart_pc_o` is zero.
- R5: The woken slot is freed on the edge that raises its wake pulse, so its `block_o` bit is low in the wake cycle.
- R6: When several slots hold the released address, only the lowest-numbered context is woken. The other matching contexts stay blocked.
- R7: A release that matches no occupied slot changes no output and no slot.
- R8: When a fail and a release arrive in the same cycle, the release is matched against the slots as they were before the fail is written. The newly written slot is never woken by that release. If the fail targets the context being woken, that slot ends up occupied with the new request.
- R9: A match requires equality on all address bits. An empty slot never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_vld_i | input | 1 | A context failed to acquire a lock this cycle |
| fail_ctx_i | input | CW | Context that failed |
| fail_lock_i | input | AW | Lock address of the failed acquire |
| fail_pc_i | input | PCW | Program counter of the acquiring instruction |
| rel_vld_i | input | 1 | A lock is released this cycle |
| rel_lock_i | input | AW | Released lock address |
| block_o | output | NCTX | Context is parked (slot occupied) |
| flush_o | output | NCTX | One-cycle flush request for a newly parked context |
| wake_o | output | NCTX | One-cycle wake pulse |
| restart_pc_o | output | PCW | Restart program counter of the woken context |

## Verification
The bench builds the table with four contexts, a 6-bit lock address and a 16-bit program counter. Random addresses are drawn mostly from eight values, so several contexts often wait on the same lock. This makes the lowest-context priority and repeated wakes on one address common events. Occasional addresses with high bits set exercise full-width matching. Directed steps cover a fail and a release in the same cycle, both for different contexts and for the context being woken.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int unsigned CTX_DEF  = 4;
    localparam int unsigned ADDR_DEF = 32;
    localparam int unsigned PC_DEF   = 32;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/lpt_match.sv
module lpt_match #(
    parameter int unsigned NCTX = 4,
    parameter int unsigned AW   = 32
) (
    input  logic                      en_i,
    input  logic [AW-1:0]             key_i,
    input  logic [NCTX-1:0]           vld_i,
    input  logic [NCTX-1:0][AW-1:0]   lock_i,
    output logic [NCTX-1:0]           hit_o
);
    for (genvar g = 0; g < NCTX; g++) begin : g_cmp
        assign hit_o[g] = en_i && vld_i[g] && (lock_i[g] == key_i);
    end
endmodule

// File: rtl/lpt_prio.sv
module lpt_prio #(
    parameter int unsigned NCTX = 4,
    localparam int unsigned CW  = lpt_pkg::idx_width(NCTX)
) (
    input  logic [NCTX-1:0] req_i,
    output logic [NCTX-1:0] gnt_o,
    output logic [CW-1:0]   idx_o,
    output logic            any_o
);
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o = '0;
                gnt_o[i] = 1'b1;
                idx_o = CW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lock_park_table.sv
module lock_park_table #(
    parameter int unsigned NCTX = lpt_pkg::CTX_DEF,
    parameter int unsigned AW   = lpt_pkg::ADDR_DEF,
    parameter int unsigned PCW  = lpt_pkg::PC_DEF,
    localparam int unsigned CW  = lpt_pkg::idx_width(NCTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_vld_i,
    input  logic [CW-1:0]    fail_ctx_i,
    input  logic [AW-1:0]    fail_lock_i,
    input  logic [PCW-1:0]   fail_pc_i,
    input  logic             rel_vld_i,
    input  logic [AW-1:0]    rel_lock_i,
    output logic [NCTX-1:0]  block_o,
    output logic [NCTX-1:0]  flush_o,
    output logic [NCTX-1:0]  wake_o,
    output logic [PCW-1:0]   restart_pc_o
);
    typedef struct packed {
        logic [NCTX-1:0]          vld;
        logic [NCTX-1:0][AW-1:0]  lock;
        logic [NCTX-1:0][PCW-1:0] pc;
        logic [NCTX-1:0]          wake;
        logic [NCTX-1:0]          flush;
        logic [PCW-1:0]           rpc;
    } state_t;

    state_t st_d, st_q;

    logic [NCTX-1:0] hit;
    logic [NCTX-1:0] gnt;
    logic [CW-1:0]   gnt_idx;
    logic            gnt_any;

    lpt_match #(.NCTX(NCTX), .AW(AW)) u_match (
        .en_i   (rel_vld_i),
        .key_i  (rel_lock_i),
        .vld_i  (st_q.vld),
        .lock_i (st_q.lock),
        .hit_o  (hit)
    );

    lpt_prio #(.NCTX(NCTX)) u_prio (
        .req_i (hit),
        .gnt_o (gnt),
        .idx_o (gnt_idx),
        .any_o (gnt_any)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wake  = gnt;
        st_d.flush = '0;
        st_d.rpc   = '0;
        // release is resolved first, against the slots before any write
        if (gnt_any) begin
            st_d.rpc          = st_q.pc[gnt_idx];
            st_d.vld[gnt_idx] = 1'b0;
        end
        if (fail_vld_i && (32'(fail_ctx_i) < NCTX)) begin
            st_d.vld[fail_ctx_i]   = 1'b1;
            st_d.lock[fail_ctx_i]  = fail_lock_i;
            st_d.pc[fail_ctx_i]    = fail_pc_i;
            st_d.flush[fail_ctx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign block_o      = st_q.vld;
    assign flush_o      = st_q.flush;
    assign wake_o       = st_q.wake;
    assign restart_pc_o = st_q.rpc;

    p_one_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_o));

    p_flush_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((flush_o & block_o) == flush_o));

    p_wake_was_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o != '0) |-> (($past(block_o) & wake_o) == wake_o));

    p_wake_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o != '0 && !$past(fail_vld_i)) |-> ((block_o & wake_o) == '0));

    p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld_i && !fail_vld_i && !gnt_any) |=> ($stable(block_o) && wake_o == '0));

    p_pc_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o == '0) |-> (restart_pc_o == '0));
endmodule

// File: tb/sim_lock_park_table.sv
module sim_lock_park_table;
    localparam int unsigned N   = 4;
    localparam int unsigned AW  = 6;
    localparam int unsigned PCW = 16;
    localparam int unsigned CW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fail_vld = 1'b0;
    logic [CW-1:0] fail_ctx = '0;
    logic [AW-1:0] fail_lock = '0;
    logic [PCW-1:0] fail_pc = '0;
    logic rel_vld = 1'b0;
    logic [AW-1:0] rel_lock = '0;
    logic [N-1:0] block, flush, wake;
    logic [PCW-1:0] rpc;

    int checks = 0;
    int errors = 0;

    logic [N-1:0]   m_vld = '0;
    logic [AW-1:0]  m_lock [N];
    logic [PCW-1:0] m_pc [N];
    logic [N-1:0]   e_wake, e_flush;
    logic [PCW-1:0] e_rpc;

    always #4 clk = ~clk;

    lock_park_table #(.NCTX(N), .AW(AW), .PCW(PCW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fail_vld_i(fail_vld), .fail_ctx_i(fail_ctx), .fail_lock_i(fail_lock), .fail_pc_i(fail_pc),
        .rel_vld_i(rel_vld), .rel_lock_i(rel_lock),
        .block_o(block), .flush_o(flush), .wake_o(wake), .restart_pc_o(rpc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected next state from the requirements (R3, R6, R8 ordering)
    function automatic int lowest_hit();
        for (int i = 0; i < N; i++)
            if (rel_vld && m_vld[i] && m_lock[i] == rel_lock) return i;
        return -1;
    endfunction

    task automatic step(input string tag);
        int h;
        h = lowest_hit();
        e_wake = '0; e_flush = '0; e_rpc = '0;
        if (h >= 0) begin
            e_wake[h] = 1'b1;
            e_rpc = m_pc[h];
            m_vld[h] = 1'b0;
        end
        if (fail_vld) begin
            m_vld[fail_ctx] = 1'b1;
            m_lock[fail_ctx] = fail_lock;
            m_pc[fail_ctx] = fail_pc;
            e_flush[fail_ctx] = 1'b1;
        end
        @(posedge clk);
        #1;
        chk({tag, " block R2 R5"}, 32'(block), 32'(m_vld));
        chk({tag, " wake R3 R6"}, 32'(wake), 32'(e_wake));
        chk({tag, " flush R2"}, 32'(flush), 32'(e_flush));
        chk({tag, " restart R4"}, 32'(rpc), 32'(e_rpc));
        fail_vld = 1'b0;
        rel_vld = 1'b0;
    endtask

    task automatic do_fail(input int c, input int a, input int p);
        fail_vld = 1'b1; fail_ctx = CW'(c); fail_lock = AW'(a); fail_pc = PCW'(p);
    endtask

    task automatic do_rel(input int a);
        rel_vld = 1'b1; rel_lock = AW'(a);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 block", 32'(block), 0);
        chk("R1 wake", 32'(wake), 0);
        chk("R1 flush", 32'(flush), 0);
        chk("R1 restart", 32'(rpc), 0);
        rst_n = 1'b1;

        do_fail(1, 5, 16'h100); step("R2");
        do_rel(9);              step("R7");
        do_fail(2, 5, 16'h200); step("R2");
        do_fail(0, 5, 16'h050); step("R2");
        do_rel(5);              step("R6");
        do_rel(5);              step("R6");
        do_fail(3, 7, 16'h777); do_rel(7); step("R8");
        do_fail(2, 5, 16'h222); do_rel(5); step("R8");
        chk("R8 refilled slot", 32'(block[2]), 1);
        do_fail(0, 6'h21, 16'h0aa); step("R9");
        do_rel(6'h01);          step("R9");
        chk("R9 no wake on partial match", 32'(wake), 0);
        do_rel(6'h21);          step("R9");

        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 9) < 3)
                do_fail($urandom_range(0, N - 1),
                        ($urandom_range(0, 15) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 7),
                        $urandom_range(0, 65535));
            if ($urandom_range(0, 9) < 4)
                do_rel(($urandom_range(0, 15) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 7));
            step("R3");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule